// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block raises a periodic interrupt at one of six power-of-two rates. It counts pulses of a 256 Hz base enable with a single divider counter. A 3-bit rate code in an 8-bit control register picks how many base pulses make up one period. Codes 1 through 6 select periods of 1, 4, 16, 64, 128 and 256 base pulses, which give 256, 64, 16, 4, 2 and 1 Hz. Code 0 turns the generator off. Code 7 is reserved and never completes a period.

At the end of each period a sticky flag sets. Software clears the flag by writing 0 to its bit. The interrupt output is the flag, gated by a nonzero rate code. This flag is separate from any other timer flags, so several sources can OR onto one shared interrupt line. A hold bit in the same register keeps the divider cleared while the calendar prescaler is held in reset.

A three-state machine controls the divider. Its states are OFF, RUN and HOLD, and its transitions are listed below.
- Reset goes to OFF.
- OFF goes to RUN when a valid code (1 to 6) is loaded and hold is clear.
- OFF goes to HOLD, and RUN goes to HOLD, when the hold bit is set.
- RUN goes to OFF when the code becomes 0 or 7.
- HOLD goes to RUN or to OFF, depending on the code, when hold is released.
- RUN restarts in place when the code changes from one valid value to another.

The divider counts only in RUN. In every other state it is held at zero.

Top module: `pit_periodic_gen`

## Requirements
- R1: After reset, rd_data reads 0x00 and both flag and irq are low.
- R2: The control register places the flag at bit 7, the rate code at bits 6:4 and the divider hold bit at bit 1. Bits 3, 2 and 0 read as 0. A write stores the code and the hold bit directly from wr_data.
- R3: With codes 1, 2, 3, 4, 5 and 6, a period is 1, 4, 16, 64, 128 and 256 base pulses respectively.
- R4: With code 0 or code 7 the flag never sets. With code 0, irq stays low.
- R5: The flag sets on the clock edge that samples the base pulse completing a period. It then stays set until software clears it.
- R6: A write with bit 7 at 0 clears the flag, and a write with bit 7 at 1 leaves the flag unchanged. If a period completes in the same cycle as a clearing write, the flag is set.
- R7: A write that changes the rate code restarts the divider. A base pulse in the write cycle is not counted, so the first period under the new code is full length.
- R8: A write that keeps the same rate code does not disturb the divider count.
- R9: While the hold bit is 1, the divider stays cleared and no period completes. After release, counting starts from zero.
- R10: irq is high exactly when the flag is set and the rate code is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle 256 Hz base enable pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| flag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
The bench builds the block with its default counter width of 8 bits, which is just wide enough for the 256-pulse period. It drives the base pulse on every cycle when it measures periods, so even the slowest rate finishes within a few hundred clocks. This makes every rate code, including the full 256-count terminal, reachable alongside restart, hold and same-cycle set-versus-clear collisions. Random write and pulse patterns then mix code changes with counting in progress.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int REG_W     = 8;
    localparam int SEL_W     = 3;
    localparam int SEL_LSB   = 4;
    localparam int FLAG_BIT  = 7;
    localparam int HOLD_BIT  = 1;
    localparam int NUM_CODES = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pit_state_e;

    // log2 of the period length, in base pulses, for each rate code
    function automatic int unsigned code_shift(input int code);
        case (code)
            1:       return 0;
            2:       return 2;
            3:       return 4;
            4:       return 6;
            5:       return 7;
            6:       return 8;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             period_hit,
    output logic [SEL_W-1:0] sel_q,
    output logic             hold_q,
    output logic             flag_q,
    output logic [SEL_W-1:0] sel_nxt,
    output logic             hold_nxt,
    output logic             sel_chg
);
    logic flag_nxt;

    always_comb begin
        sel_nxt  = wr_en ? wr_data[SEL_LSB +: SEL_W] : sel_q;
        hold_nxt = wr_en ? wr_data[HOLD_BIT] : hold_q;
        sel_chg  = wr_en && (wr_data[SEL_LSB +: SEL_W] != sel_q);
        if (period_hit)
            flag_nxt = 1'b1;
        else if (wr_en && !wr_data[FLAG_BIT])
            flag_nxt = 1'b0;
        else
            flag_nxt = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            hold_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            sel_q  <= sel_nxt;
            hold_q <= hold_nxt;
            flag_q <= flag_nxt;
        end
    end
endmodule

// File: rtl/pit_seq.sv
module pit_seq
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_nxt,
    input  logic             hold_nxt,
    output logic             run
);
    pit_state_e state_q, state_d;
    logic       code_ok;

    assign code_ok = (sel_nxt != '0) && (sel_nxt <= SEL_W'(NUM_CODES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (hold_nxt)     state_d = ST_HOLD;
                else if (code_ok) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (hold_nxt)      state_d = ST_HOLD;
                else if (!code_ok) state_d = ST_OFF;
            end
            ST_HOLD: begin
                if (!hold_nxt) state_d = code_ok ? ST_RUN : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end
endmodule

// File: rtl/pit_divider.sv
module pit_divider
    import pit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] sel_q,
    output logic             period_hit
);
    localparam int SLOTS = 2 ** SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [SLOTS-1:0] term_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_term
        if (g >= 1 && g <= NUM_CODES) begin : g_live
            localparam int unsigned SH = code_shift(g);
            localparam logic [CNT_W-1:0] TM = CNT_W'((1 << SH) - 1);
            assign term_hit[g] = (cnt_q == TM);
        end else begin : g_dead
            assign term_hit[g] = 1'b0;
        end
    end

    assign period_hit = run && base_tick && !restart && term_hit[sel_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || restart)
            cnt_q <= '0;
        else if (base_tick)
            cnt_q <= period_hit ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/pit_periodic_gen.sv
module pit_periodic_gen
    import pit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             flag,
    output logic             irq
);
    logic [SEL_W-1:0] sel_q, sel_nxt;
    logic             hold_q, hold_nxt, flag_q, sel_chg, run, period_hit;

    pit_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .period_hit(period_hit), .sel_q(sel_q), .hold_q(hold_q),
        .flag_q(flag_q), .sel_nxt(sel_nxt), .hold_nxt(hold_nxt),
        .sel_chg(sel_chg)
    );

    pit_seq u_seq (
        .clk(clk), .rst_n(rst_n), .sel_nxt(sel_nxt), .hold_nxt(hold_nxt),
        .run(run)
    );

    pit_divider #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(sel_chg),
        .base_tick(base_tick), .sel_q(sel_q), .period_hit(period_hit)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[FLAG_BIT]          = flag_q;
        rd_data[SEL_LSB +: SEL_W]  = sel_q;
        rd_data[HOLD_BIT]          = hold_q;
    end

    assign flag = flag_q;
    assign irq  = flag_q && (sel_q != '0);
endmodule

// File: rtl/pit_periodic_chk.sv
module pit_periodic_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       base_tick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       flag,
    input logic       irq
);
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    a_r10_irq_off_code0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6:4] == 3'd0) |-> !irq);

    a_r5_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(base_tick));

    a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |=> !$rose(flag));

    a_r4_code7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6:4] == 3'd7) |=> !$rose(flag));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_en && !wr_data[7] && !base_tick) |=> !flag);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_en) |=> flag);
endmodule

bind pit_periodic_gen pit_periodic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .flag(flag), .irq(irq)
);

// File: tb/pit_periodic_gen_test.sv
`timescale 1ns/1ps
module pit_periodic_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       flag, irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    logic [2:0] m_sel = 3'd0;
    logic       m_hold = 1'b0;
    logic       m_flag = 1'b0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    pit_periodic_gen uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .flag(flag), .irq(irq)
    );

    function automatic int exp_period(input logic [2:0] code);
        case (code)
            3'd1: return 1;
            3'd2: return 4;
            3'd3: return 16;
            3'd4: return 64;
            3'd5: return 128;
            3'd6: return 256;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd();
        return {m_flag, m_sel, 2'b00, m_hold, 1'b0};
    endfunction

    task automatic check(input string t, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    task automatic cyc(input bit tk, input bit we, input logic [7:0] wd);
        bit run, chg, hit;
        base_tick = tk; wr_en = we; wr_data = wd;
        @(posedge clk);
        run = (m_sel >= 3'd1) && (m_sel <= 3'd6) && !m_hold;
        chg = we && (wd[6:4] != m_sel);
        hit = run && tk && !chg && (m_cnt == exp_period(m_sel) - 1);
        if (!run || chg)  m_cnt = 0;
        else if (tk)      m_cnt = hit ? 0 : m_cnt + 1;
        if (hit)                m_flag = 1'b1;
        else if (we && !wd[7])  m_flag = 1'b0;
        if (we) begin
            m_sel  = wd[6:4];
            m_hold = wd[1];
        end
        @(negedge clk);
        base_tick = 1'b0; wr_en = 1'b0;
        check(tag, "rd_data", int'(rd_data), int'(exp_rd()));
        check(tag, "flag", int'(flag), int'(m_flag));
        check(tag, "irq", int'(irq), int'(m_flag && (m_sel != 3'd0)));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ticks until flag sets, capped
    task automatic count_ticks(output int n);
        n = 0;
        for (int k = 1; k <= 300; k++) begin
            cyc(1'b1, 1'b0, 8'h00);
            if (flag) begin n = k; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1", "reset rd_data", int'(rd_data), 0);
        check("R1", "reset flag", int'(flag), 0);
        check("R1", "reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every rate code, measured from the code-loading write
        tag = "R3";
        for (int c = 1; c <= 6; c++) begin
            cyc(1'b0, 1'b1, {1'b0, 3'(c), 4'h0});
            count_ticks(n);
            check("R3", $sformatf("period code %0d", c), n, exp_period(3'(c)));
        end

        // R4: codes 7 and 0 never set the flag
        tag = "R4";
        cyc(1'b0, 1'b1, 8'h70);
        for (int k = 0; k < 300; k++) cyc(1'b1, 1'b0, 8'h00);
        check("R4", "flag code 7", int'(flag), 0);
        cyc(1'b0, 1'b1, 8'h00);
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, 8'h00);
        check("R4", "irq code 0", int'(irq), 0);

        // R10: flag kept, code 0 masks irq
        tag = "R10";
        cyc(1'b0, 1'b1, 8'h10);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h80);
        check("R10", "irq masked", int'(irq), 0);
        check("R10", "flag kept", int'(flag), 1);
        cyc(1'b0, 1'b1, 8'h90);
        check("R10", "irq unmasked", int'(irq), 1);

        // R6: write 1 keeps, write 0 clears, hit beats clear
        tag = "R6";
        cyc(1'b0, 1'b1, 8'h90);
        check("R6", "write1 keeps", int'(flag), 1);
        cyc(1'b0, 1'b1, 8'h10);
        check("R6", "write0 clears", int'(flag), 0);
        cyc(1'b1, 1'b1, 8'h10);
        check("R6", "set wins", int'(flag), 1);

        // R7: code change with coincident tick restarts
        tag = "R7";
        cyc(1'b0, 1'b1, 8'h20);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b1, 8'h30);
        count_ticks(n);
        check("R7", "full first period", n, 16);

        // R8: same-code write keeps count
        tag = "R8";
        cyc(1'b0, 1'b1, 8'h20);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h20);
        count_ticks(n);
        check("R8", "remaining ticks", n, 2);

        // R9: hold keeps divider cleared
        tag = "R9";
        cyc(1'b0, 1'b1, 8'h22);
        for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0, 8'h00);
        check("R9", "flag under hold", int'(flag), 0);
        cyc(1'b0, 1'b1, 8'h20);
        count_ticks(n);
        check("R9", "period after release", n, 4);

        // R2: field placement
        tag = "R2";
        cyc(1'b0, 1'b1, 8'hFF);
        check("R2", "field layout", int'(rd_data), int'({flag, 3'b111, 2'b00, 1'b1, 1'b0}));

        // R5: random mix against the model
        tag = "R5";
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] wd;
            bit tk, we;
            tk = ($urandom % 3) != 0;
            we = ($urandom % 30) == 0;
            wd = 8'($urandom);
            wd[6:4] = 3'(1 + ($urandom % 3));
            if (($urandom % 8) == 0) wd[6:4] = 3'($urandom % 8);
            if (($urandom % 4) != 0) wd[1] = 1'b0;
            cyc(tk, we, wd);
        end

        summary();
        $finish;
    end
endmodule